// File: doc/BRIEF.md
# Cycle-Swallowing Fractional Frequency Generator

This block produces a square wave whose average frequency can be placed far more finely than a single tick of its timebase clock would allow. Most output periods last a nominal number of ticks. Within each averaging window of a programmed number of output periods, a signed correction count selects how many periods are trimmed by exactly one tick. A positive count shortens those periods, which raises the average frequency. A negative count lengthens them, which lowers it.

The trimmed periods are spread evenly through the window by an error-accumulator rule. Frequency accuracy is therefore exact over a whole window, while any single period is off by at most one tick. For example, with a 10 ns tick, a nominal period of 100 ticks, a window of 100000 periods and a correction of +1, the average output is 1000000.1 Hz.

Settings are sampled only when a new window opens. Two strobes mark period starts and window starts for downstream logic. The three settings are static control levels rather than a data stream, so they have no valid/ready handshake. The block applies no back-pressure, and the strobes cannot be stalled.

Top module: `fracgen`

## Requirements
- R1: While reset is asserted, the wave, period strobe and window strobe are all low. The first period after reset is released also opens a window, so both strobes are high in the first cycle after release.
- R2: With a correction of 0, every period lasts exactly the nominal count N ticks. In a period of length P, the wave is high for the first floor(P/2) ticks and low for the rest.
- R3: A positive correction c makes exactly c periods in each window N-1 ticks long. All other periods in the window are N ticks long.
- R4: A negative correction -c makes exactly c periods in each window N+1 ticks long. All other periods in the window are N ticks long.
- R5: Period j of a window (0-based, window length W, magnitude m) is adjusted if and only if floor((j+1)*m/W) > floor(j*m/W).
- R6: The period strobe is high for exactly one cycle, which is the first tick of every period.
- R7: The window strobe is high only together with the period strobe of the first period of a window. Each window holds exactly W periods.
- R8: Changes to the nominal count, window length or correction made during a window have no effect until the next window begins.
- R9: A correction magnitude equal to W adjusts every period of the window.
- R10: Each window lasts exactly W*N - c ticks, where c is the signed correction.
- Preconditions: N >= 3, W >= 1, |c| <= W. The correction is two's complement, and its top bit is the sign.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timebase clock; one tick per cycle |
| rst | input | 1 | Synchronous reset, active high |
| nom_period_i | input | PER_W | Nominal period length in ticks (N) |
| win_len_i | input | WIN_W | Averaging window length in periods (W) |
| corr_i | input | WIN_W+1 | Signed count of periods to trim per window |
| wave_o | output | 1 | Square-wave output |
| period_stb_o | output | 1 | One-cycle pulse on the first tick of each period |
| window_stb_o | output | 1 | One-cycle pulse on the first tick of each window |

## Verification
The embedded assertions check the following properties on every cycle:
- Each strobe lasts a single cycle.
- The window strobe never appears without the period strobe.
- The wave rises only at a period start.
- The behaviour after reset release is correct.
- The error accumulator and the period index stay below the window length.
- The latched settings are held steady inside a window.

Some properties can only be shown by the bench's scenarios, which compare against a per-tick reference model:
- Which periods get trimmed, and the even spread of those periods.
- The exact period and window lengths.
- The delayed take-up of settings changed in mid-window.
- The long-run strobe and tick totals over many windows.

// File: rtl/fgen_pkg.sv
package fgen_pkg;
  localparam int DEF_PER_W = 16;
  localparam int DEF_WIN_W = 20;

  typedef enum logic {
    CORR_SHORTEN = 1'b0,
    CORR_STRETCH = 1'b1
  } corr_dir_e;
endpackage

// File: rtl/fgen_window.sv
module fgen_window
  import fgen_pkg::*;
#(
  parameter int PER_W = DEF_PER_W,
  parameter int WIN_W = DEF_WIN_W,
  localparam int LEN_W = PER_W + 1,
  localparam int ACC_W = WIN_W + 2
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   started_i,
  input  logic                   boundary_i,
  input  logic [PER_W-1:0]       nom_i,
  input  logic [WIN_W-1:0]       win_i,
  input  logic signed [WIN_W:0]  corr_i,
  output logic [LEN_W-1:0]       len_o,
  output logic                   win_start_o
);
  logic [PER_W-1:0] act_nom, sel_nom;
  logic [WIN_W-1:0] act_win, sel_win, pidx_q;
  logic [WIN_W:0]   act_mag, sel_mag, in_mag;
  corr_dir_e        act_dir, sel_dir, in_dir;
  logic [ACC_W-1:0] acc_q, base, sum;
  logic             adj;
  logic [LEN_W-1:0] nom_ext;

  always_comb begin
    in_dir      = corr_i[WIN_W] ? CORR_STRETCH : CORR_SHORTEN;
    in_mag      = corr_i[WIN_W] ? $unsigned(-corr_i) : $unsigned(corr_i);
    win_start_o = !started_i || (pidx_q == act_win - WIN_W'(1));
    sel_nom     = win_start_o ? nom_i  : act_nom;
    sel_win     = win_start_o ? win_i  : act_win;
    sel_mag     = win_start_o ? in_mag : act_mag;
    sel_dir     = win_start_o ? in_dir : act_dir;
    base        = win_start_o ? '0 : acc_q;
    sum         = base + ACC_W'(sel_mag);
    adj         = sum >= ACC_W'(sel_win);
    nom_ext     = LEN_W'(sel_nom);
    if (!adj)                       len_o = nom_ext;
    else if (sel_dir == CORR_SHORTEN) len_o = nom_ext - LEN_W'(1);
    else                            len_o = nom_ext + LEN_W'(1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      act_nom <= '0;
      act_win <= '0;
      act_mag <= '0;
      act_dir <= CORR_SHORTEN;
      acc_q   <= '0;
      pidx_q  <= '0;
    end else if (boundary_i) begin
      if (win_start_o) begin
        act_nom <= nom_i;
        act_win <= win_i;
        act_mag <= in_mag;
        act_dir <= in_dir;
        pidx_q  <= '0;
      end else begin
        pidx_q  <= pidx_q + WIN_W'(1);
      end
      acc_q <= adj ? (sum - ACC_W'(sel_win)) : sum;
    end
  end

  // R5
  acc_bound_chk: assert property (@(posedge clk) disable iff (rst)
    started_i |-> (acc_q < ACC_W'(act_win)));

  // R7
  pidx_bound_chk: assert property (@(posedge clk) disable iff (rst)
    started_i |-> (pidx_q < act_win));

  // R8
  settings_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (started_i && !win_start_o) |=> ($stable(act_nom) && $stable(act_win)
                                     && $stable(act_mag) && $stable(act_dir)));
endmodule

// File: rtl/fgen_period.sv
module fgen_period #(
  parameter int LEN_W = 17
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LEN_W-1:0] len_i,
  input  logic             win_start_i,
  output logic             boundary_o,
  output logic             started_o,
  output logic             wave_o,
  output logic             pstb_o,
  output logic             wstb_o
);
  logic [LEN_W-1:0] cnt_q, len_q;

  assign boundary_o = !started_o || (cnt_q == len_q - LEN_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      started_o <= 1'b0;
      cnt_q     <= '0;
      len_q     <= '0;
      wave_o    <= 1'b0;
      pstb_o    <= 1'b0;
      wstb_o    <= 1'b0;
    end else if (boundary_o) begin
      started_o <= 1'b1;
      cnt_q     <= '0;
      len_q     <= len_i;
      wave_o    <= (len_i >> 1) != '0;
      pstb_o    <= 1'b1;
      wstb_o    <= win_start_i;
    end else begin
      cnt_q     <= cnt_q + LEN_W'(1);
      wave_o    <= (cnt_q + LEN_W'(1)) < (len_q >> 1);
      pstb_o    <= 1'b0;
      wstb_o    <= 1'b0;
    end
  end

  // R6
  pstb_single_chk: assert property (@(posedge clk) disable iff (rst)
    pstb_o |=> !pstb_o);

  // R7
  wstb_with_pstb_chk: assert property (@(posedge clk) disable iff (rst)
    wstb_o |-> pstb_o);

  // R2
  wave_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(wave_o) |-> pstb_o);

  // R1
  reset_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (!wave_o && !pstb_o && !wstb_o));

  // R1
  first_window_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |=> (pstb_o && wstb_o));
endmodule

// File: rtl/fracgen.sv
module fracgen
  import fgen_pkg::*;
#(
  parameter int PER_W = DEF_PER_W,
  parameter int WIN_W = DEF_WIN_W,
  localparam int LEN_W = PER_W + 1
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [PER_W-1:0]      nom_period_i,
  input  logic [WIN_W-1:0]      win_len_i,
  input  logic signed [WIN_W:0] corr_i,
  output logic                  wave_o,
  output logic                  period_stb_o,
  output logic                  window_stb_o
);
  logic [LEN_W-1:0] next_len;
  logic             win_start, boundary, started;

  fgen_window #(.PER_W(PER_W), .WIN_W(WIN_W)) win_u (
    .clk(clk), .rst(rst), .started_i(started), .boundary_i(boundary),
    .nom_i(nom_period_i), .win_i(win_len_i), .corr_i(corr_i),
    .len_o(next_len), .win_start_o(win_start)
  );

  fgen_period #(.LEN_W(LEN_W)) per_u (
    .clk(clk), .rst(rst), .len_i(next_len), .win_start_i(win_start),
    .boundary_o(boundary), .started_o(started), .wave_o(wave_o),
    .pstb_o(period_stb_o), .wstb_o(window_stb_o)
  );
endmodule

// File: tb/fracgen_tb_top.sv
module fracgen_tb_top;
  localparam int PW = 16;
  localparam int WW = 20;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [PW-1:0] nom = PW'(10);
  logic [WW-1:0] win = WW'(4);
  logic signed [WW:0] corr = '0;
  wire wave, pstb, wstb;

  always #10 clk = ~clk;

  fracgen #(.PER_W(PW), .WIN_W(WW)) dut_i (
    .clk(clk), .rst(rst), .nom_period_i(nom), .win_len_i(win), .corr_i(corr),
    .wave_o(wave), .period_stb_o(pstb), .window_stb_o(wstb)
  );

  int n_chk = 0, n_fail = 0, wd = 0;
  int lens_q[$];
  int m_tick, m_len, cur_total, prev_total, since_ws;
  bit m_on = 0, have_prev = 0;

  task automatic chk(bit ok, string tag, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic build_window();
    int n, w, c, m, l;
    bit a;
    n = int'(nom); w = int'(win); c = int'(corr);
    m = (c < 0) ? -c : c;
    cur_total = 0;
    for (int j = 0; j < w; j++) begin
      a = (((j + 1) * m) / w) != ((j * m) / w);
      l = !a ? n : ((c > 0) ? n - 1 : n + 1);
      lens_q.push_back(l);
      cur_total += l;
    end
  endtask

  // Per-tick reference model, sampled away from the active edge
  always @(negedge clk) begin : model
    bit ws, bnd, ew;
    ws = 0; bnd = 0;
    if (rst) begin
      m_on = 0; have_prev = 0; lens_q.delete();
      chk(!wave && !pstb && !wstb, "R1 outputs low in reset", {wave, pstb, wstb}, 0);
    end else begin
      if (!m_on || m_tick == m_len - 1) begin
        bnd = 1;
        if (!m_on || lens_q.size() == 0) begin
          ws = 1;
          build_window();
        end
        m_len = lens_q.pop_front();
        m_tick = 0;
        m_on = 1;
      end else begin
        m_tick++;
      end
      if (ws) begin
        if (have_prev) chk(since_ws == prev_total, "R10 window length ticks", since_ws, prev_total);
        prev_total = cur_total; have_prev = 1; since_ws = 0;
      end
      since_ws++;
      ew = m_tick < (m_len / 2);
      chk(pstb == bnd, "R6 period strobe", pstb, bnd);
      chk(wstb == ws, "R7 R1 window strobe", wstb, ws);
      chk(wave == ew, "R2 R3 R4 R5 R8 R9 wave level", wave, ew);
    end
  end

  task automatic drive_at_negedge();
    @(negedge clk); #2;
  endtask

  task automatic wait_windows(int k);
    int seen = 0;
    while (seen < k) begin
      @(negedge clk);
      if (wstb) seen++;
    end
  endtask

  // Counts cycles and period strobes over k whole windows
  task automatic measure(int k, output int cy, output int ps);
    int seen = 0;
    wait_windows(1);
    cy = 1; ps = 1;
    forever begin
      @(negedge clk);
      if (wstb) begin
        seen++;
        if (seen == k) break;
      end
      cy++;
      ps += pstb ? 1 : 0;
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    wd++;
    if (wd == 150000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", wd, 0);
      finish_run();
    end
  end

  initial begin
    int cy, ps;
    repeat (3) @(posedge clk);
    drive_at_negedge(); rst = 1'b0;
    // R2: plain periods
    wait_windows(3);
    // R3 R8: positive trim, applied mid-window
    drive_at_negedge(); corr = 21'sd1;
    wait_windows(3);
    // R4 R5: negative trim, odd period length
    drive_at_negedge(); nom = PW'(11); win = WW'(5); corr = -21'sd3;
    wait_windows(3);
    // R9: every period shortened, then every period stretched
    drive_at_negedge(); nom = PW'(7); win = WW'(3); corr = 21'sd3;
    wait_windows(3);
    drive_at_negedge(); corr = -21'sd3;
    wait_windows(3);
    // R5: uneven spread
    drive_at_negedge(); nom = PW'(9); win = WW'(7); corr = 21'sd3;
    wait_windows(3);
    // R1: reset in mid-run
    drive_at_negedge(); rst = 1'b1;
    repeat (2) @(negedge clk);
    #2 rst = 1'b0;
    wait_windows(2);
    // R7 R10: long-run totals
    drive_at_negedge(); nom = PW'(10); win = WW'(100); corr = 21'sd1;
    wait_windows(1);
    measure(10, cy, ps);
    chk(ps == 1000, "R7 period strobes in 10 windows", ps, 1000);
    chk(cy == 9990, "R10 ticks in 10 windows", cy, 9990);
    finish_run();
  end
endmodule